// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Sixteenth-Bit Stop Control

This block turns one character at a time, handed over on a valid/ready pair, into an asynchronous line frame. A frame is a low start bit, followed by 5 to 8 data bits sent least significant bit first, an optional parity bit, and a high stop period. The stop period is set in sixteenths of a bit time and can be up to two bits long. Bit timing comes from an external clock-enable pulse (`tickEn`). In 16X mode each bit lasts 16 pulses. In 1X mode each bit lasts one pulse.

A break request holds the line low for as long as it stays asserted. While the break lasts, a one-cycle pulse marks the end of each full character time, so that software can count how many break characters have gone out. An optional clear-to-send input gates the start of each new character. A character already on the line always runs to its end.

Top module: `asyncTx`

## Requirements
- R1: After reset and between frames the line `txd` is 1. After reset `inReady` is 1 when `breakReq` is 0 and the clear-to-send gate is open.
- R2: A frame is accepted on a clock edge where `inValid` and `inReady` are both 1. From the next cycle the line sends a 0 start bit, then `5 + cfgLen` data bits of `inData` starting with bit 0.
- R3: `cfgParity` selects the parity bit that follows the data: 0 none, 1 even (the bit equals the XOR of the sent data bits), 2 odd (the inverse of that XOR), 3 forced to `cfgForceVal`.
- R4: With `cfgX16` = 1 each start, data and parity bit lasts 16 `tickEn` pulses. With `cfgX16` = 0 each lasts 1 pulse. A bit ends on the clock edge where its last pulse is seen.
- R5: In 16X mode the stop period lasts `cfgStop + 1` pulses, from 1/16 up to 2 bit times.
- R6: In 1X mode the stop length `cfgStop + 1` sixteenths is rounded to the nearest whole bit, ties rounding up, with a minimum of one bit.
- R7: `inReady` is 0 from the accepting edge until the edge that ends the stop period. A new frame can be accepted on the edge right after that.
- R8: With `ctsEn` = 1 and `cts` = 0, `inReady` is 0 and no new frame starts. A frame already started still completes.
- R9: A break starts only between frames and wins over pending data. It drives `txd` to 0, and `breakTick` pulses for one cycle each time a full character time of `tickEn` pulses has passed. A character time is start plus data plus parity plus stop, counted as for a frame.
- R10: On the clock edge after `breakReq` has fallen during a break, `txd` returns to 1 and the transmitter is idle.
- R11: Without `tickEn` pulses, a frame in progress does not advance and `txd` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Bit-clock enable pulse, 16X or 1X |
| cfgX16 | input | 1 | 1 selects 16 pulses per bit, 0 selects 1 |
| cfgLen | input | 2 | Data bits minus five |
| cfgParity | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 forced |
| cfgForceVal | input | 1 | Parity value sent in forced mode |
| cfgStop | input | 5 | Stop length in sixteenths, minus one |
| ctsEn | input | 1 | Enables clear-to-send gating |
| cts | input | 1 | Clear to send, active high |
| breakReq | input | 1 | Break command |
| inValid | input | 1 | Character offered |
| inData | input | 8 | Character to send |
| inReady | output | 1 | Character can be taken this cycle |
| txd | output | 1 | Serial line output |
| breakTick | output | 1 | One-cycle pulse per elapsed break character time |

## Verification
The assertions assume that the configuration inputs change only while the transmitter is idle. They also assume that `tickEn` is a plain one-cycle enable and never a level that has meaning of its own. The stimulus changes `cfgX16`, `cfgLen`, `cfgParity`, `cfgStop` and `cfgForceVal` only after `inReady` has come back, and outside any break. The bench varies the `tickEn` spacing only through a pulse generator, and it freezes that generator for a while in the middle of a frame. A behavioural model turns each accepted character into a per-pulse list of line levels, then compares the line, `inReady` and `breakTick` on every clock.

// File: rtl/asyncTxPkg.sv
package asyncTxPkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PARITY,
    PH_STOP,
    PH_BREAK
  } txPhase_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic     load;
    logic     shift;
    txPhase_e phase;
  } txStrobe_t;

  localparam logic [1:0] PAR_NONE  = 2'd0;
  localparam logic [1:0] PAR_EVEN  = 2'd1;
  localparam logic [1:0] PAR_ODD   = 2'd2;
  localparam logic [1:0] PAR_FORCE = 2'd3;

endpackage

// File: rtl/asyncTxCtrl.sv
module asyncTxCtrl
  import asyncTxPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5,
  parameter int LEN_W   = 2,
  parameter int STOP_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              cfgX16,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic              parOn,
  input  logic [STOP_W-1:0] cfgStop,
  input  logic              ctsEn,
  input  logic              cts,
  input  logic              breakReq,
  input  logic              inValid,
  output logic              inReady,
  output logic              breakTick,
  output txStrobe_t         strobe
);

  localparam int BIT_W    = $clog2(DATA_W);
  localparam int TCNT_W   = STOP_W + 1;
  localparam int CHAR_MAX = (DATA_W + 2) * 16 + (1 << STOP_W);
  localparam int BRK_W    = $clog2(CHAR_MAX + 1);

  txPhase_e           state;
  logic [TCNT_W-1:0]  tickCnt;
  logic [BIT_W-1:0]   bitIdx;
  logic [BRK_W-1:0]   brkCnt;

  logic [TCNT_W-1:0]  bitTicks, stopTicks, stop16, stopWhole, phaseLen;
  logic [TCNT_W:0]    roundSum;
  logic [BIT_W:0]     dataLen;
  logic [BRK_W-1:0]   bitsPerChar, charTicks;
  logic               lastTick, lastBit, accept;

  // Stop length: sixteenths in 16X mode, nearest whole bit in 1X mode
  always_comb begin
    stop16    = TCNT_W'(cfgStop) + TCNT_W'(1);
    roundSum  = {1'b0, stop16} + (TCNT_W + 1)'(8);
    stopWhole = TCNT_W'(roundSum >> 4);
    if (stopWhole == '0) stopWhole = TCNT_W'(1);
    stopTicks = cfgX16 ? stop16 : stopWhole;
    bitTicks  = cfgX16 ? TCNT_W'(16) : TCNT_W'(1);
    phaseLen  = (state == PH_STOP) ? stopTicks : bitTicks;
  end

  assign dataLen     = (BIT_W + 1)'(MIN_LEN) + (BIT_W + 1)'(cfgLen);
  assign bitsPerChar = BRK_W'(dataLen) + BRK_W'(1) + BRK_W'(parOn);
  assign charTicks   = (cfgX16 ? (bitsPerChar << 4) : bitsPerChar) + BRK_W'(stopTicks);

  assign lastTick = tickEn && (tickCnt == phaseLen - TCNT_W'(1));
  assign lastBit  = ({1'b0, bitIdx} == dataLen - (BIT_W + 1)'(1));
  assign inReady  = (state == PH_IDLE) && !breakReq && (!ctsEn || cts);
  assign accept   = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= PH_IDLE;
      tickCnt   <= '0;
      bitIdx    <= '0;
      brkCnt    <= '0;
      breakTick <= 1'b0;
    end else begin
      breakTick <= 1'b0;
      if (state inside {PH_START, PH_DATA, PH_PARITY, PH_STOP}) begin
        if (lastTick)    tickCnt <= '0;
        else if (tickEn) tickCnt <= tickCnt + TCNT_W'(1);
      end
      unique case (state)
        PH_IDLE: begin
          if (breakReq) begin
            state  <= PH_BREAK;
            brkCnt <= '0;
          end else if (accept) begin
            state   <= PH_START;
            tickCnt <= '0;
          end
        end
        PH_START: if (lastTick) begin
          state  <= PH_DATA;
          bitIdx <= '0;
        end
        PH_DATA: if (lastTick) begin
          if (lastBit) state <= parOn ? PH_PARITY : PH_STOP;
          else         bitIdx <= bitIdx + BIT_W'(1);
        end
        PH_PARITY: if (lastTick) state <= PH_STOP;
        PH_STOP:   if (lastTick) state <= PH_IDLE;
        PH_BREAK: begin
          if (!breakReq) begin
            state <= PH_IDLE;
          end else if (tickEn) begin
            if (brkCnt == charTicks - BRK_W'(1)) begin
              brkCnt    <= '0;
              breakTick <= 1'b1;
            end else begin
              brkCnt <= brkCnt + BRK_W'(1);
            end
          end
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  assign strobe.load  = accept;
  assign strobe.shift = (state == PH_DATA) && lastTick;
  assign strobe.phase = state;

  assert_cts_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctsEn && !cts) |-> !inReady);
  assert_break_priority_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_IDLE && breakReq) |=> (state == PH_BREAK));
  assert_breaktick_in_break_R9: assert property (@(posedge clk) disable iff (!rstN)
    breakTick |-> (state == PH_BREAK));
  assert_break_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_BREAK && !breakReq) |=> (state == PH_IDLE));
  assert_no_tick_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && state inside {PH_START, PH_DATA, PH_PARITY, PH_STOP})
      |=> ($stable(state) && $stable(tickCnt)));
  assert_bit_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {PH_START, PH_DATA, PH_PARITY}) |-> (tickCnt < bitTicks));

endmodule

// File: rtl/asyncTxDp.sv
module asyncTxDp
  import asyncTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic [1:0]        cfgParity,
  input  logic              cfgForceVal,
  output logic              txd
);

  logic [DATA_W-1:0] shReg;
  logic              parAcc;
  logic              parBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      parAcc <= 1'b0;
    end else if (strobe.load) begin
      shReg  <= inData;
      parAcc <= 1'b0;
    end else if (strobe.shift) begin
      shReg  <= shReg >> 1;
      parAcc <= parAcc ^ shReg[0];
    end
  end

  always_comb begin
    unique case (cfgParity)
      PAR_EVEN:  parBit = parAcc;
      PAR_ODD:   parBit = ~parAcc;
      PAR_FORCE: parBit = cfgForceVal;
      default:   parBit = 1'b1;
    endcase
  end

  always_comb begin
    unique case (strobe.phase)
      PH_START, PH_BREAK: txd = 1'b0;
      PH_DATA:            txd = shReg[0];
      PH_PARITY:          txd = parBit;
      default:            txd = 1'b1;
    endcase
  end

  assert_start_follows_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !txd);
  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.phase == PH_IDLE) |-> txd);

endmodule

// File: rtl/asyncTx.sv
module asyncTx
  import asyncTxPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5,
  parameter int STOP_W  = 5,
  localparam int LEN_W  = $clog2(DATA_W - MIN_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              cfgX16,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic [1:0]        cfgParity,
  input  logic              cfgForceVal,
  input  logic [STOP_W-1:0] cfgStop,
  input  logic              ctsEn,
  input  logic              cts,
  input  logic              breakReq,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              txd,
  output logic              breakTick
);

  txStrobe_t strobe;

  asyncTxCtrl #(
    .DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W), .STOP_W(STOP_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cfgX16(cfgX16),
    .cfgLen(cfgLen), .parOn(cfgParity != PAR_NONE), .cfgStop(cfgStop),
    .ctsEn(ctsEn), .cts(cts), .breakReq(breakReq), .inValid(inValid),
    .inReady(inReady), .breakTick(breakTick), .strobe(strobe)
  );

  asyncTxDp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .cfgParity(cfgParity), .cfgForceVal(cfgForceVal), .txd(txd)
  );

endmodule

// File: tb/tb_asyncTx.sv
`timescale 1ns/1ps
module tb_asyncTx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       cfgX16 = 1'b1;
  logic [1:0] cfgLen = 2'd3;
  logic [1:0] cfgParity = 2'd0;
  logic       cfgForceVal = 1'b0;
  logic [4:0] cfgStop = 5'd15;
  logic       ctsEn = 1'b0;
  logic       cts = 1'b1;
  logic       breakReq = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       inReady, txd, breakTick;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";

  int tickDiv = 2;
  int tickPhase = 0;
  bit tickFreeze = 0;

  int  q[$];
  bit  mBrk = 0;
  int  mBrkCnt = 0;
  bit  expTick = 0;
  int  gotTicks = 0;
  int  expTicks = 0;

  always #4 clk = ~clk;

  asyncTx dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cfgX16(cfgX16), .cfgLen(cfgLen),
    .cfgParity(cfgParity), .cfgForceVal(cfgForceVal), .cfgStop(cfgStop),
    .ctsEn(ctsEn), .cts(cts), .breakReq(breakReq), .inValid(inValid),
    .inData(inData), .inReady(inReady), .txd(txd), .breakTick(breakTick)
  );

  // Pulse generator for the bit clock enable.
  always @(posedge clk) begin
    #2;
    tickPhase++;
    tickEn = !tickFreeze && ((tickPhase % tickDiv) == 0);
  end

  function automatic int stopTicksOf();
    int n = int'(cfgStop) + 1;
    int w;
    if (cfgX16) return n;
    w = (n + 8) / 16;            // R6 rounding
    return (w == 0) ? 1 : w;
  endfunction

  function automatic int charTicksOf();
    int bitT = cfgX16 ? 16 : 1;
    int nb = 1 + 5 + int'(cfgLen) + ((cfgParity != 2'd0) ? 1 : 0);
    return nb * bitT + stopTicksOf();
  endfunction

  task automatic buildFrame(input logic [7:0] d);
    int bitT = cfgX16 ? 16 : 1;
    int len = 5 + int'(cfgLen);
    bit x = 0;
    bit p;
    for (int k = 0; k < bitT; k++) q.push_back(0);
    for (int i = 0; i < len; i++) begin
      x = x ^ d[i];
      for (int k = 0; k < bitT; k++) q.push_back(int'(d[i]));
    end
    if (cfgParity != 2'd0) begin
      p = (cfgParity == 2'd1) ? x : (cfgParity == 2'd2) ? !x : cfgForceVal;
      for (int k = 0; k < bitT; k++) q.push_back(int'(p));
    end
    for (int k = 0; k < stopTicksOf(); k++) q.push_back(1);
  endtask

  // Behavioural reference, advanced on every rising edge.
  always @(posedge clk) begin
    bit rdy;
    if (!rstN) begin
      q.delete();
      mBrk = 0;
      mBrkCnt = 0;
      expTick = 0;
    end else begin
      rdy = !mBrk && (q.size() == 0) && !breakReq && (!ctsEn || cts);
      expTick = 0;
      if (mBrk) begin
        if (!breakReq) mBrk = 0;
        else if (tickEn) begin
          mBrkCnt++;
          if (mBrkCnt == charTicksOf()) begin
            mBrkCnt = 0;
            expTick = 1;
            expTicks++;
          end
        end
      end else if (q.size() == 0) begin
        if (breakReq) begin
          mBrk = 1;
          mBrkCnt = 0;
        end else if (inValid && rdy) begin
          buildFrame(inData);
        end
      end else if (tickEn) begin
        void'(q.pop_front());
      end
    end
  end

  // Compare at the falling edge.
  always @(negedge clk) begin
    logic eTxd, eRdy;
    if (rstN) begin
      eTxd = (q.size() != 0) ? logic'(q[0]) : (mBrk ? 1'b0 : 1'b1);
      eRdy = !mBrk && (q.size() == 0) && !breakReq && (!ctsEn || cts);
      if (breakTick) gotTicks++;
      checks++;
      if (txd !== eTxd || inReady !== eRdy || breakTick !== expTick) begin
        fails++;
        $display("FAIL %s at %0t: txd/rdy/brk actual %b%b%b expected %b%b%b",
                 curReq, $time, txd, inReady, breakTick, eTxd, eRdy, expTick);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d);
    inData = d;
    inValid = 1'b1;
    forever begin
      @(negedge clk);
      if (inReady) begin
        @(posedge clk);
        #2;
        inValid = 1'b0;
        break;
      end
    end
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (!inReady);
    repeat (3) @(posedge clk);
    #2;
  endtask

  task automatic run();
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(txd === 1'b1, "R1", int'(txd), 1);
    check(inReady === 1'b1, "R1", int'(inReady), 1);
    @(posedge clk); #2; rstN = 1'b1;
    repeat (5) @(posedge clk); #2;

    // R2 R4 R5: 8 data bits, no parity, one stop bit in 16X
    curReq = "R2";
    send(8'h55); send(8'hA3); waitIdle();

    // R3 R5: 5 bits even parity, 3/16 stop; back-to-back frames (R7)
    curReq = "R3";
    cfgLen = 2'd0; cfgParity = 2'd1; cfgStop = 5'd2; tickDiv = 1;
    send(8'h17); send(8'h0E); waitIdle();
    curReq = "R5";
    cfgLen = 2'd2; cfgParity = 2'd2; cfgStop = 5'd23;
    send(8'h6D); send(8'h01); waitIdle();
    curReq = "R3";
    cfgLen = 2'd1; cfgParity = 2'd3; cfgForceVal = 1'b0;
    send(8'h3F); waitIdle();
    cfgForceVal = 1'b1; cfgStop = 5'd31;
    send(8'h20); waitIdle();

    // R6 R4: 1X mode rounding of the stop length
    curReq = "R6";
    cfgX16 = 1'b0; tickDiv = 3; cfgLen = 2'd3; cfgParity = 2'd1;
    cfgStop = 5'd23; send(8'hC5); waitIdle();
    cfgStop = 5'd7;  send(8'h3A); waitIdle();
    cfgStop = 5'd3;  send(8'hFF); waitIdle();
    cfgStop = 5'd31; send(8'h81); send(8'h7E); waitIdle();

    // R11: no enable pulses freezes the frame
    curReq = "R11";
    cfgX16 = 1'b1; tickDiv = 2; cfgStop = 5'd15; cfgParity = 2'd0;
    send(8'h96);
    repeat (40) @(posedge clk); #2;
    tickFreeze = 1;
    repeat (30) @(posedge clk); #2;
    tickFreeze = 0;
    waitIdle();

    // R8: clear-to-send gating
    curReq = "R8";
    ctsEn = 1'b1; cts = 1'b0; inData = 8'h3C; inValid = 1'b1;
    repeat (40) @(posedge clk); #2;
    cts = 1'b1;
    send(8'h3C);
    repeat (20) @(posedge clk); #2;
    cts = 1'b0;                    // frame in progress completes
    inData = 8'h44; inValid = 1'b1;
    repeat (500) @(posedge clk); #2;
    cts = 1'b1;
    send(8'h44); waitIdle();
    ctsEn = 1'b0;

    // R9 R10: break requested mid-frame with data pending
    curReq = "R9";
    send(8'hF0);
    breakReq = 1'b1; inData = 8'h99; inValid = 1'b1;
    repeat (3 * charTicksOf() * tickDiv + 300) @(posedge clk); #2;
    curReq = "R10";
    breakReq = 1'b0;
    send(8'h99); waitIdle();
    // R9 in 1X mode
    curReq = "R9";
    cfgX16 = 1'b0; tickDiv = 1; cfgParity = 2'd2; cfgStop = 5'd20;
    breakReq = 1'b1;
    repeat (5 * charTicksOf() + 3) @(posedge clk); #2;
    breakReq = 1'b0;
    repeat (4) @(posedge clk); #2;
    check(gotTicks == expTicks && expTicks >= 6, "R9", gotTicks, expTicks);
    check(txd === 1'b1, "R10", int'(txd), 1);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R7: watchdog actual hung expected finished");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule